// File: doc/BRIEF.md
# Status Register and Write-Protect Gate

This block keeps the status byte of a small serial nonvolatile memory and rules on every array or status write that the command decoder asks for. It holds a write-enable latch and a two-bit block-protect code, and it takes the busy flag from the programming timer. For each write request it weighs the write-protect pin, the latch, the busy flag and, for array writes, whether the target address falls inside the protected range. One cycle later it answers with either a grant pulse or a reject pulse.

The decoder feeds it one-cycle enable and disable commands, and a write request with its address and data byte. The timer sends a completion pulse when a programming cycle ends, and that pulse clears the write-enable latch. The protect code has a reset value and keeps its contents in an ordinary register. Serial shifting and the memory array sit outside this block.

Top module: `wp_status_ctrl`

## Requirements
- R1: When not busy, the status byte reads bits 7..4 as 0, bits 3..2 as the protect code, bit 1 as the write-enable latch and bit 0 as the busy flag.
- R2: After reset the write-enable latch is 0, the protect code equals BP_RESET (0 by default, so the status byte reads 0x00), and grant and reject are low.
- R3: An enable command sets the latch and a disable command clears it, both visible the next cycle. When both arrive in the same cycle, disable wins.
- R4: For a depth of 2^ADDR_W bytes the protect code selects the protected range. Code 00 protects nothing, 01 protects the upper quarter (0x180–0x1FF at 9 bits), 10 the upper half (0x100–0x1FF) and 11 the whole array.
- R5: A request raises grant for exactly one cycle, one cycle after the request, only when wp_n is 1, the latch is 1, busy is 0, and the request either targets the status register or has an address outside the protected range.
- R6: A request that is not granted raises reject for exactly one cycle and leaves the latch and the protect code unchanged. This includes every request made while the latch is 0.
- R7: A cycle_done pulse clears the latch in the next cycle, even when an enable command arrives in the same cycle.
- R8: A granted status write loads the protect code from data bits 3..2. Data bits 7..4 and 1..0 have no effect.
- R9: While busy is 1, the status byte reads 0x01 and every request is rejected.
- R10: wp_n does not affect the enable or disable commands or the status byte. A cycle granted before wp_n falls still clears the latch on its cycle_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wren | input | 1 | Decoded enable-writes command pulse |
| cmd_wrdi | input | 1 | Decoded disable-writes command pulse |
| req_valid | input | 1 | Write request pulse |
| req_is_status | input | 1 | 1 = status write, 0 = array write |
| req_addr | input | ADDR_W | Target array address |
| req_data | input | 8 | Byte for a status write |
| wp_n | input | 1 | Active-low write-protect pin |
| busy | input | 1 | Programming cycle in progress |
| cycle_done | input | 1 | Programming cycle completed pulse |
| status_byte | output | 8 | Status byte for reads |
| grant | output | 1 | Request allowed pulse |
| reject | output | 1 | Request denied pulse |
| bp_level | output | 2 | Current protect code |

## Verification
The bench builds the block with ADDR_W = 9 and BP_RESET = 0. With these values the exact range edges 0x17F/0x180, 0x0FF/0x100, 0x000 and 0x1FF are testable, and so is a status byte of 0x00 right after reset. All four protect codes are walked through in turn, and at each code the bench probes an address on both sides of the boundary. The directed part covers the busy masking, the race between cycle_done and an enable command, and a protect pin that falls during a cycle already granted.

// File: rtl/ws_pkg.sv
package ws_pkg;
    localparam int unsigned BP_W = 2;

    typedef struct packed {
        logic            wen;
        logic [BP_W-1:0] bp;
        logic            grant;
        logic            reject;
    } ws_state_t;
endpackage

// File: rtl/ws_range_chk.sv
module ws_range_chk #(
    parameter int unsigned ADDR_W = 9
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [3:0] lvl_hit;

    assign lvl_hit[0] = 1'b0;

    for (genvar lvl = 1; lvl < 4; lvl++) begin : g_lvl
        localparam int unsigned LO_INT = DEPTH - (DEPTH >> (3 - lvl));
        localparam logic [ADDR_W:0] LO = LO_INT[ADDR_W:0];
        assign lvl_hit[lvl] = ({1'b0, addr} >= LO);
    end

    assign hit = lvl_hit[bp];
endmodule

// File: rtl/ws_status_fmt.sv
module ws_status_fmt (
    input  logic       wen,
    input  logic [1:0] bp,
    input  logic       busy,
    output logic [7:0] status_byte
);
    always_comb begin
        if (busy) begin
            status_byte = 8'h01;
        end else begin
            status_byte = {4'h0, bp, wen, 1'b0};
        end
    end
endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl #(
    parameter int unsigned ADDR_W   = 9,
    parameter logic [1:0]  BP_RESET = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              req_valid,
    input  logic              req_is_status,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              wp_n,
    input  logic              busy,
    input  logic              cycle_done,
    output logic [7:0]        status_byte,
    output logic              grant,
    output logic              reject,
    output logic [1:0]        bp_level
);
    import ws_pkg::*;

    localparam ws_state_t RESET_STATE = '{wen: 1'b0, bp: BP_RESET, grant: 1'b0, reject: 1'b0};

    ws_state_t st_d, st_q;
    logic      prot_hit;
    logic      allowed;
    logic      unused_data;

    assign unused_data = ^{req_data[7:4], req_data[1:0]};

    ws_range_chk #(.ADDR_W(ADDR_W)) u_range (
        .bp   (st_q.bp),
        .addr (req_addr),
        .hit  (prot_hit)
    );

    ws_status_fmt u_fmt (
        .wen         (st_q.wen),
        .bp          (st_q.bp),
        .busy        (busy),
        .status_byte (status_byte)
    );

    always_comb begin
        st_d        = st_q;
        st_d.grant  = 1'b0;
        st_d.reject = 1'b0;
        allowed     = wp_n && st_q.wen && !busy && (req_is_status || !prot_hit);

        if (cmd_wren)   st_d.wen = 1'b1;
        if (cmd_wrdi)   st_d.wen = 1'b0;
        if (cycle_done) st_d.wen = 1'b0;

        if (req_valid) begin
            if (allowed) begin
                st_d.grant = 1'b1;
                if (req_is_status) st_d.bp = req_data[3:2];
            end else begin
                st_d.reject = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign grant    = st_q.grant;
    assign reject   = st_q.reject;
    assign bp_level = st_q.bp;
endmodule

// File: rtl/wp_status_ctrl_chk.sv
module wp_status_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       wp_n,
    input logic       busy,
    input logic       cycle_done,
    input logic [7:0] status_byte,
    input logic       grant,
    input logic       reject,
    input logic [1:0] bp_level
);
    // R1
    status_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[7:4] == 4'h0);

    // R5
    grant_needs_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ($past(wp_n) && $past(req_valid) && !$past(busy)));

    // R6
    grant_reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && reject));

    // R6
    denied_wen_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !status_byte[1]) |=> reject);

    // R7
    done_clears_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> (!status_byte[1] || busy));

    // R8
    bp_change_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bp_level) |-> grant);

    // R9
    busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (status_byte == 8'h01));
endmodule

bind wp_status_ctrl wp_status_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .wp_n        (wp_n),
    .busy        (busy),
    .cycle_done  (cycle_done),
    .status_byte (status_byte),
    .grant       (grant),
    .reject      (reject),
    .bp_level    (bp_level)
);

// File: tb/sim_wp_status_ctrl.sv
module sim_wp_status_ctrl;
    localparam int unsigned ADDR_W = 9;
    localparam int NVEC = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_wren = 1'b0, cmd_wrdi = 1'b0;
    logic              req_valid = 1'b0, req_is_status = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_data = '0;
    logic              wp_n = 1'b1, busy = 1'b0, cycle_done = 1'b0;
    logic [7:0]        status_byte;
    logic              grant, reject;
    logic [1:0]        bp_level;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wp_status_ctrl #(.ADDR_W(ADDR_W), .BP_RESET(2'b00)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
        .req_valid(req_valid), .req_is_status(req_is_status), .req_addr(req_addr),
        .req_data(req_data), .wp_n(wp_n), .busy(busy), .cycle_done(cycle_done),
        .status_byte(status_byte), .grant(grant), .reject(reject), .bp_level(bp_level)
    );

    // {wren, wrdi, req, is_status, wp_n, addr[8:0], data[7:0], exp_grant, exp_reject, exp_status[7:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {5'b00111, 9'h000, 8'h00, 2'b01, 8'h00}, // R6 request with latch clear
        {5'b10001, 9'h000, 8'h00, 2'b00, 8'h02}, // R3 enable
        {5'b11001, 9'h000, 8'h00, 2'b00, 8'h00}, // R3 both, disable wins
        {5'b10001, 9'h000, 8'h00, 2'b00, 8'h02}, // R3 enable
        {5'b00101, 9'h1FF, 8'h00, 2'b10, 8'h02}, // R4 code 00 top address
        {5'b00111, 9'h000, 8'hF4, 2'b10, 8'h06}, // R8 code 01, upper bits ignored
        {5'b00101, 9'h180, 8'h00, 2'b01, 8'h06}, // R4 code 01 edge inside
        {5'b00101, 9'h17F, 8'h00, 2'b10, 8'h06}, // R4 code 01 edge outside
        {5'b00110, 9'h000, 8'h08, 2'b01, 8'h06}, // R5 pin low
        {5'b10000, 9'h000, 8'h00, 2'b00, 8'h06}, // R10 enable with pin low
        {5'b00111, 9'h000, 8'h0B, 2'b10, 8'h0A}, // R8 code 10, bits 1..0 ignored
        {5'b00101, 9'h100, 8'h00, 2'b01, 8'h0A}, // R4 code 10 edge inside
        {5'b00101, 9'h0FF, 8'h00, 2'b10, 8'h0A}, // R4 code 10 edge outside
        {5'b00111, 9'h000, 8'h0C, 2'b10, 8'h0E}, // R8 code 11
        {5'b00101, 9'h000, 8'h00, 2'b01, 8'h0E}, // R4 code 11 bottom address
        {5'b00111, 9'h000, 8'h00, 2'b10, 8'h02}, // R5 status write ignores range
        {5'b01001, 9'h000, 8'h00, 2'b00, 8'h00}, // R3 disable
        {5'b00111, 9'h000, 8'h0C, 2'b01, 8'h00}  // R6 status write, latch clear
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 17:                   return "R6";
            1, 2, 3, 16:             return "R3";
            4, 6, 7, 11, 12, 14:     return "R4";
            5, 10, 13:               return "R8";
            8, 15:                   return "R5";
            default:                 return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cmd_wren = 0; cmd_wrdi = 0; req_valid = 0; req_is_status = 0;
        cycle_done = 0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2", status_byte, 8'h00);
        chk("R2", {6'b0, grant, reject}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", {6'b0, bp_level}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] v;
            v = VEC[i];
            cmd_wren = v[31]; cmd_wrdi = v[30]; req_valid = v[29];
            req_is_status = v[28]; wp_n = v[27]; req_addr = v[26:18];
            req_data = v[17:10];
            @(negedge clk);
            chk(vec_tag(i), {6'b0, grant, reject}, {6'b0, v[9], v[8]});
            chk(vec_tag(i), status_byte, v[7:0]);
        end
        idle(); wp_n = 1;

        // R6 reject lasts one cycle
        @(negedge clk);
        chk("R6", {7'b0, reject}, 8'h00);

        // R9 busy masks the status and rejects requests
        cmd_wren = 1; @(negedge clk); idle();
        chk("R1", status_byte, 8'h02);
        busy = 1; #1;
        chk("R9", status_byte, 8'h01);
        req_valid = 1; req_is_status = 0; req_addr = 9'h000;
        @(negedge clk); idle();
        chk("R9", {6'b0, grant, reject}, 8'h01);

        // R7 done overrides enable in the same cycle
        busy = 0; cycle_done = 1; cmd_wren = 1;
        @(negedge clk); idle();
        chk("R7", status_byte, 8'h00);

        // R10 pin falls during a granted cycle; done still clears the latch
        cmd_wren = 1; @(negedge clk); idle();
        req_valid = 1; req_addr = 9'h010; @(negedge clk); idle();
        chk("R5", {7'b0, grant}, 8'h01);
        wp_n = 0; busy = 1; @(negedge clk);
        busy = 0; cycle_done = 1; @(negedge clk); idle();
        chk("R10", status_byte, 8'h00);
        wp_n = 1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule